// File: doc/BRIEF.md
# Signed Precision-Reduction Rounding Stage

This block narrows a signed two's-complement sample by discarding its low-order bits. It is placed at the tail of a transform datapath, where guard bits carried through the earlier arithmetic must be removed before the sample leaves. The widths and the rounding policy are fixed at elaboration. The policy is chosen by a 2-bit parameter from four options:

- plain truncation
- round half up
- round half away from zero
- round half to even

Every policy has exactly one register of latency. A sample strobe travels through a matching register, so it stays aligned with the rounded word. Complex samples use two instances, one for each component.

The policies differ only in how they treat the discarded fraction. A fraction strictly above one half rounds up. A fraction strictly below one half rounds down. An exact half follows the tie rule of the chosen policy. Truncation ignores the fraction entirely. The increment is added in the kept-width domain and is allowed to wrap: the most positive value, rounded up, becomes the most negative value.

Top module: `rnd_stage`

## Requirements
- R1: With `MODE`=0, `out_data` equals the input with its `IN_W-OUT_W` low bits removed, with no adjustment, whatever those bits hold.
- R2: With `MODE`=1, an exact half (top discarded bit 1, the rest 0) increments the kept value.
- R3: With `MODE`=2, an exact half on a non-negative input increments the kept value. On a negative input it leaves the kept value alone, so the result is the neighbour further from zero.
- R4: With `MODE`=3, an exact half yields whichever neighbour has a kept least significant bit of 0.
- R5: `out_data` and `out_sync` present the result for the input sampled at one rising clock edge, and change only at that edge, exactly one cycle later.
- R6: In every mode, a discarded fraction below one half (top discarded bit 0) yields the kept value unchanged.
- R7: With `MODE` 1, 2 or 3, a discarded fraction above one half (top discarded bit 1, some lower discarded bit 1) increments the kept value.
- R8: An increment applied to the largest positive kept value wraps modulo 2^`OUT_W` to the most negative value.
- R9: A synchronous active-high `rst` clears `out_sync` and `out_data` at the next rising edge.
- R10: When `IN_W-OUT_W` is 1, every input whose dropped bit is 1 is treated as an exact half by the tie rule of the chosen mode.
- R11: `IN_W` must exceed `OUT_W`. The default configuration is 20 bits in and 16 bits out, in half-to-even mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sync | input | 1 | Strobe accompanying the input sample |
| in_data | input | IN_W | Wide signed input sample |
| out_sync | output | 1 | Strobe delayed by one cycle |
| out_data | output | OUT_W | Rounded, narrowed signed sample |

## Verification
Each rounded word and its strobe are due at the first rising edge after the input is applied. The bench changes inputs on falling edges and reads outputs on the following falling edge, which is one register stage later. Reset clearing is due at the first rising edge with `rst` high, and the bench reads it half a cycle later. The bench sweeps every input of an 8-to-5-bit and a 6-to-5-bit configuration in all four modes and compares each output against floor-division arithmetic.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef enum logic [1:0] {
        RND_TRUNC   = 2'd0,
        RND_HALF_UP = 2'd1,
        RND_AWAY    = 2'd2,
        RND_EVEN    = 2'd3
    } rnd_mode_e;

endpackage

// File: rtl/rnd_frac_classify.sv
// Splits the discarded fraction into the half bit and a "something below half" flag.
module rnd_frac_classify #(
    parameter int DROP = 4
) (
    input  logic [DROP-1:0] frac,
    output logic            half_bit,
    output logic            below_nz
);

    assign half_bit = frac[DROP-1];

    generate
        if (DROP > 1) begin : g_wide
            assign below_nz = |frac[DROP-2:0];
        end else begin : g_single
            // With one dropped bit, nothing lies below the half bit: every set bit is a tie (R10).
            assign below_nz = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/rnd_bump_select.sv
// Decides whether the kept value is incremented, according to the policy.
module rnd_bump_select
    import rnd_pkg::*;
#(
    parameter int MODE = 3
) (
    input  logic half_bit,
    input  logic below_nz,
    input  logic sign,
    input  logic keep_lsb,
    output logic bump
);

    localparam rnd_mode_e POLICY = rnd_mode_e'(MODE[1:0]);

    logic tie;
    assign tie = half_bit & ~below_nz;

    generate
        case (POLICY)
            RND_TRUNC: begin : g_trunc
                logic unused_in;
                assign unused_in = half_bit ^ below_nz ^ sign ^ keep_lsb ^ tie;
                assign bump = 1'b0;
            end
            RND_HALF_UP: begin : g_half_up
                logic unused_in;
                assign unused_in = sign ^ keep_lsb ^ tie ^ below_nz;
                assign bump = half_bit;
            end
            RND_AWAY: begin : g_away
                // Negative ties keep the floor value, which is further from zero.
                logic unused_in;
                assign unused_in = keep_lsb;
                assign bump = half_bit & (~tie | ~sign);
            end
            default: begin : g_even
                logic unused_in;
                assign unused_in = sign;
                assign bump = half_bit & (~tie | keep_lsb);
            end
        endcase
    endgenerate

endmodule

// File: rtl/rnd_pipe_reg.sv
// One-cycle output register for the data word and its strobe.
module rnd_pipe_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         d_sync,
    input  logic [W-1:0] d_data,
    output logic         q_sync,
    output logic [W-1:0] q_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_sync <= 1'b0;
            q_data <= '0;
        end else begin
            q_sync <= d_sync;
            q_data <= d_data;
        end
    end

endmodule

// File: rtl/rnd_stage.sv
module rnd_stage
    import rnd_pkg::*;
#(
    parameter int IN_W  = 20,
    parameter int OUT_W = 16,
    parameter int MODE  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_sync,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_sync,
    output logic [OUT_W-1:0] out_data
);

    localparam int DROP = IN_W - OUT_W;

    logic [OUT_W-1:0] kept;
    logic [DROP-1:0]  frac;
    logic             half_bit;
    logic             below_nz;
    logic             bump;
    logic [OUT_W-1:0] rounded;

    assign kept = in_data[IN_W-1:DROP];
    assign frac = in_data[DROP-1:0];

    rnd_frac_classify #(.DROP(DROP)) u_cls (
        .frac     (frac),
        .half_bit (half_bit),
        .below_nz (below_nz)
    );

    rnd_bump_select #(.MODE(MODE)) u_sel (
        .half_bit (half_bit),
        .below_nz (below_nz),
        .sign     (in_data[IN_W-1]),
        .keep_lsb (kept[0]),
        .bump     (bump)
    );

    // The sum is taken modulo 2^OUT_W: a rounded-up maximum wraps (R8).
    assign rounded = kept + OUT_W'(bump);

    rnd_pipe_reg #(.W(OUT_W)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .d_sync (in_sync),
        .d_data (rounded),
        .q_sync (out_sync),
        .q_data (out_data)
    );

endmodule

// File: rtl/rnd_stage_chk.sv
module rnd_stage_chk #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 16,
    parameter int MODE  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             in_sync,
    input logic [IN_W-1:0]  in_data,
    input logic             out_sync,
    input logic [OUT_W-1:0] out_data
);

    localparam int DROP = IN_W - OUT_W;

    logic             tie_in;
    logic             above_in;
    logic [OUT_W-1:0] kept_in;

    assign kept_in = in_data[IN_W-1:DROP];

    generate
        if (DROP > 1) begin : g_wide
            assign tie_in   = in_data[DROP-1] && (in_data[DROP-2:0] == '0);
            assign above_in = in_data[DROP-1] && (in_data[DROP-2:0] != '0);
        end else begin : g_single
            assign tie_in   = in_data[0];
            assign above_in = 1'b0;
        end
    endgenerate

    assert_sync_hi_R5: assert property (@(posedge clk) disable iff (rst)
        in_sync |=> out_sync);
    assert_sync_lo_R5: assert property (@(posedge clk) disable iff (rst)
        !in_sync |=> !out_sync);
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!out_sync && out_data == '0));
    assert_below_half_R6: assert property (@(posedge clk) disable iff (rst)
        !in_data[DROP-1] |=> out_data == $past(kept_in));

    generate
        if (MODE == 0) begin : g_a_trunc
            assert_trunc_R1: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> out_data == $past(kept_in));
        end else begin : g_a_round
            assert_above_half_R7: assert property (@(posedge clk) disable iff (rst)
                above_in |=> out_data == $past(kept_in) + OUT_W'(1));
            if (MODE == 1) begin : g_a_hu
                assert_tie_up_R2: assert property (@(posedge clk) disable iff (rst)
                    tie_in |=> out_data == $past(kept_in) + OUT_W'(1));
            end else if (MODE == 2) begin : g_a_away
                assert_tie_pos_R3: assert property (@(posedge clk) disable iff (rst)
                    (tie_in && !in_data[IN_W-1]) |=> out_data == $past(kept_in) + OUT_W'(1));
                assert_tie_neg_R3: assert property (@(posedge clk) disable iff (rst)
                    (tie_in && in_data[IN_W-1]) |=> out_data == $past(kept_in));
            end else begin : g_a_even
                assert_tie_even_R4: assert property (@(posedge clk) disable iff (rst)
                    tie_in |=> !out_data[0]);
            end
        end
    endgenerate

endmodule

bind rnd_stage rnd_stage_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .MODE(MODE)) u_chk (.*);

// File: tb/tb_rnd_stage.sv
module tb_rnd_stage;

    localparam int CLK_PERIOD = 10;
    localparam int OW = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_sync = 1'b0;
    logic [7:0] in_a = '0;
    logic [5:0] in_b = '0;

    logic [OW-1:0] oa [4];
    logic [OW-1:0] ob [4];
    logic          sa [4];
    logic          sb [4];

    int n_checks = 0;
    int n_errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar m = 0; m < 4; m++) begin : g_a
        rnd_stage #(.IN_W(8), .OUT_W(OW), .MODE(m)) dut (
            .clk(clk), .rst(rst), .in_sync(in_sync), .in_data(in_a),
            .out_sync(sa[m]), .out_data(oa[m]));
    end
    for (genvar m = 0; m < 4; m++) begin : g_b
        rnd_stage #(.IN_W(6), .OUT_W(OW), .MODE(m)) dut (
            .clk(clk), .rst(rst), .in_sync(in_sync), .in_data(in_b),
            .out_sync(sb[m]), .out_data(ob[m]));
    end

    // Reference: floor division, then the tie rule, then reduction modulo 2^OW.
    function automatic int ref_round(int v, int drop, int mode);
        int unit = 1 << drop;
        int half = unit >> 1;
        int kept = (v >= 0) ? v / unit : -((-v + unit - 1) / unit);
        int frac = v - kept * unit;
        int r = kept;
        if (mode != 0) begin
            if (frac > half) r = kept + 1;
            else if (frac == half) begin
                if (mode == 1) r = kept + 1;
                else if (mode == 2) r = (v >= 0) ? kept + 1 : kept;
                else r = ((kept % 2) != 0) ? kept + 1 : kept;
            end
        end
        return r & ((1 << OW) - 1);
    endfunction

    function automatic string tag_of(int v, int drop, int mode);
        int unit = 1 << drop;
        int half = unit >> 1;
        int kept = (v >= 0) ? v / unit : -((-v + unit - 1) / unit);
        int frac = v - kept * unit;
        if (drop == 1 && frac != 0) return "R10";
        if (mode == 0) return "R1";
        if (kept == 15 && frac >= half && !(mode == 3 && frac == half && kept % 2 == 0)) return "R8";
        if (frac < half) return "R6";
        if (frac > half) return "R7";
        if (mode == 1) return "R2";
        if (mode == 2) return "R3";
        return "R4";
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            check("R9", int'(sa[m]), 0, "reset strobe A");
            check("R9", int'(oa[m]), 0, "reset data A");
            check("R9", int'(sb[m]), 0, "reset strobe B");
        end
        rst = 1'b0;

        // R11: widest-to-narrowest configuration, default rule at narrow scale,
        // exhaustive sweep with R5 latency check on every step.
        for (int v = 0; v < 256; v++) begin
            int sv;
            int svb;
            @(negedge clk);
            in_a = v[7:0];
            in_b = v[5:0];
            in_sync = v[1] ^ v[3];
            @(negedge clk);
            sv  = (v >= 128) ? v - 256 : v;
            svb = (v[5:0] >= 32) ? int'(v[5:0]) - 64 : int'(v[5:0]);
            for (int m = 0; m < 4; m++) begin
                check(tag_of(sv, 3, m), int'(oa[m]), ref_round(sv, 3, m), $sformatf("A mode %0d in %0d", m, sv));
                check(tag_of(svb, 1, m), int'(ob[m]), ref_round(svb, 1, m), $sformatf("B mode %0d in %0d", m, svb));
                check("R5", int'(sa[m]), int'(v[1] ^ v[3]), "strobe delay");
            end
        end

        // R5: output holds until the next rising edge
        @(negedge clk);
        in_a = 8'd20;
        in_sync = 1'b1;
        #1;
        check("R5", int'(oa[1]), ref_round(-1, 3, 1), "no change before edge");
        @(negedge clk);
        check("R5", int'(oa[1]), 3, "value after edge");
        check("R5", int'(sa[1]), 1, "strobe after edge");

        // R8: explicit wrap of max positive
        @(negedge clk);
        in_a = 8'd127;
        @(negedge clk);
        check("R8", int'(oa[1]), 16, "wrap half-up");
        check("R8", int'(oa[0]), 15, "no wrap trunc");

        // R9: mid-stream synchronous reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            check("R9", int'(sa[m]), 0, "mid reset strobe");
            check("R9", int'(oa[m]), 0, "mid reset data");
        end
        rst = 1'b0;
        in_sync = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule